// File: doc/BRIEF.md
# Delegating Interrupt Priority Selector

This block holds the pending, enable and delegation masks of a core that handles traps at machine and supervisor level. From those masks, the current privilege and the two global enable bits, it picks the interrupt to take and the privilege that takes it. The pick is combinational, so the trap logic can sample `irq_valid`, `irq_cause` and `irq_priv` in the same cycle. The block also supplies the supervisor-visible views of the pending and enable masks, and applies the legal write rules when control-register writes arrive.

Pending interrupts are split into two groups. Those not delegated stay with machine mode. Those delegated go to supervisor mode. Each group has its own implicit enable, which depends on the current privilege. Within a group a fixed priority order applies. The machine group is always examined first.

The machine-level pending bits (external, timer, software) follow three interrupt lines that are registered every cycle. The supervisor pending bits are written by software. The user pending bits are always zero.

Top module: `irq_deleg_sel`

## Requirements
- R1: While `rst_n` is low, all mask registers are zero. After reset, `irq_valid` is 0 and every view reads zero.
- R2: Bit positions in all 12-bit masks: 11 MEI, 9 SEI, 8 UEI, 7 MTI, 5 STI, 4 UTI, 3 MSI, 1 SSI, 0 USI. `irq_cause` equals the bit index of the chosen interrupt.
- R3: When pending AND enabled is zero, `irq_valid` is 0.
- R4: Non-delegated interrupts target machine level (`irq_priv` = 3). They are taken when `priv` is not 3. They are also taken when `priv` is 3 and `glb_mie` is 1. Privilege encoding: 0 user, 1 supervisor, 3 machine. Code 2 counts as below machine and has no supervisor enable.
- R5: Delegated interrupts target supervisor (`irq_priv` = 1). They are taken when `priv` is 0, or when `priv` is 1 and `glb_sie` is 1. They are never taken while `priv` is 3.
- R6: If the machine group has a takeable interrupt, it wins over any supervisor candidate.
- R7: Within a group the order is MEI, MSI, MTI, SEI, SSI, STI, UEI, USI, UTI, highest first.
- R8: `sip_o` equals `mip_o & mideleg_o & 0x333`, and `sie_o` equals `mie_o & mideleg_o & 0x333`.
- R9: A write with `wr_sel` = 3 (supervisor enable) changes only the enable bits whose delegation bit is set among 0x333.
- R10: A write with `wr_sel` = 4 (supervisor pending) changes only SSI (bit 1), and only when mideleg bit 1 is set.
- R11: A write with `wr_sel` = 0 (machine pending) changes only bits 9, 5 and 1. Bits 11, 7 and 3 load `m_lines[2]`, `m_lines[1]` and `m_lines[0]` every cycle. The user bits stay zero.
- R12: A write with `wr_sel` = 1 (machine enable) changes only bits 11, 9, 7, 5, 3 and 1.
- R13: A write with `wr_sel` = 2 (delegation) loads `wr_data & 0x333`. Bits 11, 7 and 3 of `mideleg_o` stay zero.
- R14: A write with `wr_sel` of 5, 6 or 7 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| glb_mie | input | 1 | Global machine interrupt enable |
| glb_sie | input | 1 | Global supervisor interrupt enable |
| m_lines | input | 3 | Machine interrupt lines: [2] external, [1] timer, [0] software |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write target: 0 mip, 1 mie, 2 mideleg, 3 sie, 4 sip |
| wr_data | input | 12 | Write value |
| mip_o | output | 12 | Machine pending mask |
| mie_o | output | 12 | Machine enable mask |
| mideleg_o | output | 12 | Delegation mask |
| sip_o | output | 12 | Supervisor view of pending |
| sie_o | output | 12 | Supervisor view of enable |
| irq_valid | output | 1 | An interrupt is to be taken |
| irq_cause | output | 4 | Cause code (bit index) |
| irq_priv | output | 2 | Target privilege |

## Verification
Several properties are checked on every cycle:
- a reported cause is always both pending and enabled;
- nothing is reported when no bit is both pending and enabled;
- the target privilege always agrees with the delegation bit of the cause;
- delegated interrupts never fire from machine mode;
- the machine delegation bits stay zero;
- a supervisor pending write with SSI not delegated leaves SSI unchanged.

The full priority order, the precedence of the machine group and the write masking of each target are shown only by the bench. It runs directed scenarios and a long random mix, compared against its own model of the masks and the selection.

// File: rtl/irq_deleg_sel.sv
module irq_deleg_sel #(
  parameter int CAUSE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         priv,
  input  logic               glb_mie,
  input  logic               glb_sie,
  input  logic [2:0]         m_lines,
  input  logic               wr_en,
  input  logic [2:0]         wr_sel,
  input  logic [11:0]        wr_data,
  output logic [11:0]        mip_o,
  output logic [11:0]        mie_o,
  output logic [11:0]        mideleg_o,
  output logic [11:0]        sip_o,
  output logic [11:0]        sie_o,
  output logic               irq_valid,
  output logic [CAUSE_W-1:0] irq_cause,
  output logic [1:0]         irq_priv
);
  localparam logic [11:0] SU_BITS   = 12'h333;
  localparam logic [11:0] MIE_WMASK = 12'hAAA;
  localparam logic [11:0] MIP_WMASK = 12'h222;
  localparam logic [1:0]  LVL_U     = 2'd0;
  localparam logic [1:0]  LVL_S     = 2'd1;
  localparam logic [1:0]  LVL_M     = 2'd3;
  localparam int          NPRIO     = 9;
  localparam logic [3:0]  ORDER [NPRIO] = '{4'd11, 4'd3, 4'd7, 4'd9, 4'd1, 4'd5, 4'd8, 4'd0, 4'd4};

  logic [11:0] pend_q, en_q, del_q;
  logic [11:0] pend_n, en_n, del_n;

  always_comb begin
    pend_n     = pend_q;
    pend_n[11] = m_lines[2];
    pend_n[7]  = m_lines[1];
    pend_n[3]  = m_lines[0];
    en_n       = en_q;
    del_n      = del_q;
    if (wr_en) begin
      case (wr_sel)
        3'd0: pend_n = (pend_n & ~MIP_WMASK) | (wr_data & MIP_WMASK);
        3'd1: en_n   = (en_q & ~MIE_WMASK) | (wr_data & MIE_WMASK);
        3'd2: del_n  = wr_data & SU_BITS;
        3'd3: en_n   = (en_q & ~(del_q & SU_BITS)) | (wr_data & del_q & SU_BITS);
        3'd4: if (del_q[1]) pend_n[1] = wr_data[1];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
      del_q  <= '0;
    end else begin
      pend_q <= pend_n;
      en_q   <= en_n;
      del_q  <= del_n;
    end
  end

  function automatic logic [4:0] first_set(input logic [11:0] v);
    logic [4:0] r;
    r = '0;
    for (int i = NPRIO - 1; i >= 0; i--)
      if (v[ORDER[i]]) r = {1'b1, ORDER[i]};
    return r;
  endfunction

  logic [11:0] act, m_grp, s_grp;
  logic        eff_m, eff_s;
  logic [4:0]  m_pick, s_pick;

  assign act    = pend_q & en_q;
  assign m_grp  = act & ~del_q;
  assign s_grp  = act & del_q;
  assign eff_m  = (priv != LVL_M) || glb_mie;
  assign eff_s  = (priv == LVL_U) || (priv == LVL_S && glb_sie);
  assign m_pick = first_set(m_grp);
  assign s_pick = first_set(s_grp);

  always_comb begin
    irq_valid = 1'b0;
    irq_cause = '0;
    irq_priv  = LVL_M;
    if (eff_m && m_pick[4]) begin
      irq_valid = 1'b1;
      irq_cause = CAUSE_W'(m_pick[3:0]);
      irq_priv  = LVL_M;
    end else if (eff_s && s_pick[4]) begin
      irq_valid = 1'b1;
      irq_cause = CAUSE_W'(s_pick[3:0]);
      irq_priv  = LVL_S;
    end
  end

  assign mip_o     = pend_q;
  assign mie_o     = en_q;
  assign mideleg_o = del_q;
  assign sip_o     = pend_q & del_q & SU_BITS;
  assign sie_o     = en_q & del_q & SU_BITS;
endmodule

// File: rtl/irq_deleg_sel_chk.sv
module irq_deleg_sel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  priv,
  input logic        wr_en,
  input logic [2:0]  wr_sel,
  input logic [11:0] wr_data,
  input logic [11:0] mip_o,
  input logic [11:0] mie_o,
  input logic [11:0] mideleg_o,
  input logic        irq_valid,
  input logic [3:0]  irq_cause,
  input logic [1:0]  irq_priv
);
  logic [11:0] cause_bit;
  assign cause_bit = 12'(1) << irq_cause;

  assert_none_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((mip_o & mie_o) == 12'h0) |-> !irq_valid);

  assert_cause_is_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> ((cause_bit & mip_o & mie_o) != 12'h0));

  assert_machine_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_priv == 2'd3) |-> ((cause_bit & mideleg_o) == 12'h0));

  assert_super_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_priv == 2'd1) |-> (((cause_bit & mideleg_o) != 12'h0) && priv != 2'd3));

  assert_deleg_m_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (mideleg_o & 12'h888) == 12'h0);

  assert_sip_guard_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd4 && !mideleg_o[1]) |=> $stable(mip_o[1]));

  assert_mip_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd0) |=> (mip_o[9] == $past(wr_data[9]) && mip_o[5] == $past(wr_data[5])
                                   && mip_o[1] == $past(wr_data[1])));
endmodule

bind irq_deleg_sel irq_deleg_sel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .priv(priv), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .mip_o(mip_o), .mie_o(mie_o), .mideleg_o(mideleg_o),
  .irq_valid(irq_valid), .irq_cause(irq_cause), .irq_priv(irq_priv)
);

// File: tb/tb_irq_deleg_sel.sv
module tb_irq_deleg_sel;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] priv = '0;
  logic glb_mie = 1'b0, glb_sie = 1'b0;
  logic [2:0] m_lines = '0;
  logic wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [11:0] wr_data = '0;
  logic [11:0] mip_o, mie_o, mideleg_o, sip_o, sie_o;
  logic irq_valid;
  logic [3:0] irq_cause;
  logic [1:0] irq_priv;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_deleg_sel dut (
    .clk(clk), .rst_n(rst_n), .priv(priv), .glb_mie(glb_mie), .glb_sie(glb_sie),
    .m_lines(m_lines), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .mip_o(mip_o), .mie_o(mie_o), .mideleg_o(mideleg_o), .sip_o(sip_o), .sie_o(sie_o),
    .irq_valid(irq_valid), .irq_cause(irq_cause), .irq_priv(irq_priv)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [11:0] m_pend = '0, m_en = '0, m_del = '0;

  task automatic chk(string tag, logic [11:0] act, logic [11:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] top_bit(input logic [11:0] v);
    if (v[11]) return 4'd11;
    else if (v[3]) return 4'd3;
    else if (v[7]) return 4'd7;
    else if (v[9]) return 4'd9;
    else if (v[1]) return 4'd1;
    else if (v[5]) return 4'd5;
    else if (v[8]) return 4'd8;
    else if (v[0]) return 4'd0;
    else return 4'd4;
  endfunction

  function automatic logic [11:0] exp_sel(input logic [11:0] p, e, d, input logic [1:0] pr, input bit gm, gs);
    logic [11:0] a, mg, sg;
    bit em, es;
    a  = p & e;
    mg = a & ~d;
    sg = a & d;
    em = (pr != 2'd3) || gm;
    es = (pr == 2'd0) || (pr == 2'd1 && gs);
    if (em && mg != 0) return {5'd0, 1'b1, 2'd3, top_bit(mg)};
    if (es && sg != 0) return {5'd0, 1'b1, 2'd1, top_bit(sg)};
    return {5'd0, 1'b0, 2'd3, 4'd0};
  endfunction

  task automatic check_all(string tag);
    logic [11:0] es;
    es = exp_sel(m_pend, m_en, m_del, priv, glb_mie, glb_sie);
    chk({tag, " mip"}, mip_o, m_pend);
    chk({tag, " mie"}, mie_o, m_en);
    chk({tag, " mideleg"}, mideleg_o, m_del);
    chk({tag, " R8 sip view"}, sip_o, m_pend & m_del & 12'h333);
    chk({tag, " R8 sie view"}, sie_o, m_en & m_del & 12'h333);
    if (es[6]) chk({tag, " selection"}, {5'd0, irq_valid, irq_priv, irq_cause}, es);
    else       chk({tag, " R3 selection"}, {11'd0, irq_valid}, 12'd0);
  endtask

  task automatic step(string tag, bit we, logic [2:0] sel, logic [11:0] d, logic [2:0] ln,
                      logic [1:0] pr, bit gm, bit gs);
    logic [11:0] np, ne, nd;
    wr_en = we; wr_sel = sel; wr_data = d; m_lines = ln; priv = pr; glb_mie = gm; glb_sie = gs;
    np = m_pend; ne = m_en; nd = m_del;
    np[11] = ln[2]; np[7] = ln[1]; np[3] = ln[0];
    if (we) begin
      if (sel == 3'd0) begin np[9] = d[9]; np[5] = d[5]; np[1] = d[1]; end
      if (sel == 3'd1) ne = (m_en & 12'h555) | (d & 12'hAAA);
      if (sel == 3'd2) nd = d & 12'h333;
      if (sel == 3'd3) for (int b = 0; b < 12; b++) if (m_del[b] && 12'h333 >> b & 1) ne[b] = d[b];
      if (sel == 3'd4 && m_del[1]) np[1] = d[1];
    end
    @(posedge clk);
    m_pend = np; m_en = ne; m_del = nd;
    @(negedge clk);
    wr_en = 1'b0;
    check_all(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1 reset");
    step("R13 deleg write", 1, 3'd2, 12'hFFF, 3'b000, 2'd3, 1, 0);
    step("R12 mie write",   1, 3'd1, 12'hFFF, 3'b000, 2'd3, 1, 0);
    step("R9 sie clear",    1, 3'd3, 12'h000, 3'b000, 2'd3, 1, 0);
    step("R13 deleg zero",  1, 3'd2, 12'h000, 3'b000, 2'd3, 1, 0);
    step("R9 sie undeleg",  1, 3'd3, 12'hFFF, 3'b000, 2'd3, 1, 0);
    step("R10 sip undeleg", 1, 3'd4, 12'hFFF, 3'b000, 2'd3, 1, 0);
    step("R13 deleg ssi",   1, 3'd2, 12'h002, 3'b000, 2'd3, 1, 0);
    step("R10 sip deleg",   1, 3'd4, 12'hFFF, 3'b000, 2'd3, 1, 0);
    step("R11 mip write",   1, 3'd0, 12'hFFF, 3'b000, 2'd3, 1, 0);
    step("R12 mie all",     1, 3'd1, 12'hFFF, 3'b000, 2'd3, 1, 0);
    step("R13 deleg none",  1, 3'd2, 12'h000, 3'b111, 2'd3, 1, 0);
    step("R7 MEI first",    0, 3'd0, 12'h000, 3'b111, 2'd3, 1, 0);
    step("R7 MSI over MTI", 0, 3'd0, 12'h000, 3'b011, 2'd3, 1, 0);
    step("R7 MTI",          0, 3'd0, 12'h000, 3'b010, 2'd3, 1, 0);
    step("R7 SEI in M grp", 0, 3'd0, 12'h000, 3'b000, 2'd3, 1, 0);
    step("R4 M blocked",    0, 3'd0, 12'h000, 3'b111, 2'd3, 0, 1);
    step("R4 from S",       0, 3'd0, 12'h000, 3'b111, 2'd1, 0, 0);
    step("R13 deleg S",     1, 3'd2, 12'h222, 3'b000, 2'd1, 0, 1);
    step("R5 S pick SEI",   0, 3'd0, 12'h000, 3'b000, 2'd1, 0, 1);
    step("R5 S no sie",     0, 3'd0, 12'h000, 3'b000, 2'd1, 0, 0);
    step("R5 from U",       0, 3'd0, 12'h000, 3'b000, 2'd0, 0, 0);
    step("R5 never in M",   0, 3'd0, 12'h000, 3'b000, 2'd3, 1, 1);
    step("R6 M over S",     0, 3'd0, 12'h000, 3'b010, 2'd1, 0, 1);
    step("R14 sel 5",       1, 3'd5, 12'h000, 3'b010, 2'd1, 0, 1);
    step("R14 sel 7",       1, 3'd7, 12'h000, 3'b010, 2'd1, 0, 1);
    step("R2 R3 idle",      1, 3'd1, 12'h000, 3'b000, 2'd0, 1, 1);
    for (int i = 0; i < 4000; i++) begin
      step("R2 R4 R5 R6 R7 random", ($urandom_range(0, 2) != 0), 3'($urandom_range(0, 7)),
           12'($urandom), 3'($urandom), 2'($urandom), 1'($urandom), 1'($urandom));
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule